// File: doc/BRIEF.md
# Burst-of-Two Double-Rate Separate-I/O SRAM

This block is a synthesizable behavioural model of a synchronous SRAM that has one bus for data going in and another for data coming out. Every access moves two beats. Double-rate transfer is modelled with a single-edge clock that runs at twice the interface rate. Each clock cycle is one half-cycle phase. The `kphase` output shows the current phase: 0 is the "rising" half and 1 is the "falling" half. Commands are taken only in phase 0, on a shared command port. Write beats come in on `din`. Read beats go out on `dout`.

The storage array is twice as wide as either data bus. Because of this, the address selects a double-width word, and each word holds two beats. On a write, the first beat is staged until the second one arrives. The block then stores the whole word in one array write, one cycle later. On a read, the block fetches one word and sends its low half first and its high half second. The beats pass through a fixed delay line into an output register. That register is clocked either from the input clock or from a separate output-clock pulse. An echo strobe toggles each time the output register is clocked. A read issued while a write is still waiting for its array update returns the new data, merged nibble by nibble under that write's masks.

The write path runs the state machine W_IDLE, W_HI, W_COMMIT:
- W_IDLE goes to W_HI on an accepted write.
- W_HI always goes to W_COMMIT.
- W_COMMIT goes to W_HI if a new write is accepted, and to W_IDLE otherwise.

The read path runs R_IDLE and R_HI:
- R_IDLE goes to R_HI on an accepted read.
- R_HI always returns to R_IDLE.

Top module: `sio_b2_sram`

## Requirements
- R1: While reset is asserted, `dout` is 0, `dvalid` is 0, `echo` is 0 and `kphase` is 0.
- R2: A command is accepted only at a clock edge where `ld_n` is 0 and `kphase` is 0. `rd_nwr`=1 selects a read and `rd_nwr`=0 selects a write. A command presented while `kphase` is 1 has no effect on the stored data or on the outputs.
- R3: The first write beat is taken with the command and the second beat at the next edge. Both are stored as one word at the command address: the first beat in bits 7:0 and the second beat in bits 15:8.
- R4: `wmask_n` is sampled with each write beat and is active low. Bit 0 gates data bits 3:0 of that beat and bit 1 gates bits 7:4. A nibble whose mask bit is 1 keeps its old stored value.
- R5: For a read accepted at edge e, bits 7:0 of the word appear on `dout` after edge e+RD_LAT-1 and bits 15:8 after edge e+RD_LAT, with `dvalid`=1 for exactly those two cycles. Whenever `dvalid` is 0, `dout` is 0.
- R6: Reads accepted at consecutive phase-0 edges produce an unbroken stream of beats with `dvalid` held at 1.
- R7: A read accepted at the edge right after a write's second beat returns the data of that write, merged per nibble with the old contents according to that write's masks.
- R8: A write accepted right after a read does not change the data that the read returns.
- R9: With `oclk_tie`=1 the output register updates at every edge. With `oclk_tie`=0 it updates only at edges where `oclk_pulse`=1. Otherwise `dout`, `dvalid` and `echo` hold their values.
- R10: `echo` inverts at every edge where the output register updates.
- R11: After reset, `kphase` alternates at every edge.
- R12: A write's array update happens two edges after its accepted command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Half-cycle clock; each edge is one beat |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld_n | input | 1 | Command strobe, active low |
| rd_nwr | input | 1 | 1 = read, 0 = write |
| addr | input | AW | Word address |
| din | input | DW | Write beat |
| wmask_n | input | DW/4 | Per-nibble write mask for the current beat, active low |
| oclk_tie | input | 1 | 1 = output register runs from the input clock |
| oclk_pulse | input | 1 | Output-clock pulse, used when `oclk_tie` is 0 |
| dout | output | DW | Read beat |
| dvalid | output | 1 | Marks a valid read beat on `dout` |
| echo | output | 1 | Toggles at each output-register update |
| kphase | output | 1 | Current phase; commands are taken when 0 |

## Verification
If the write state machine is stuck or skips W_COMMIT, the next read of that address returns stale or mixed nibbles. That read shows the fault RD_LAT edges after it is issued. A missing or wrongly selected bypass shows up only for a read that lands on the commit edge, so the bench issues reads in exactly that slot. A wrong beat order, wrong latency or a wrong R_HI sequence shows up as a swapped or shifted beat on the first read. Errors in the output clock or echo logic show up within one edge, as a stale or changing `dout`, `dvalid` or `echo` while updates are blocked.

// File: rtl/sio_pkg.sv
package sio_pkg;

    // Write path: stage low beat, take high beat, commit to array
    typedef enum logic [1:0] {
        W_IDLE   = 2'd0,
        W_HI     = 2'd1,
        W_COMMIT = 2'd2
    } wr_state_t;

    // Read path: emit low half, then high half
    typedef enum logic {
        R_IDLE = 1'b0,
        R_HI   = 1'b1
    } rd_state_t;

endpackage

// File: rtl/sio_wr_demux.sv
module sio_wr_demux
    import sio_pkg::*;
#(
    parameter int DW = 8,
    parameter int AW = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start,
    input  logic [AW-1:0]         addr,
    input  logic [DW-1:0]         din,
    input  logic [DW/4-1:0]       mask_n,
    output logic                  commit,
    output logic [AW-1:0]         c_addr,
    output logic [2*DW-1:0]       c_word,
    output logic [DW/2-1:0]       c_nen
);
    localparam int NIB = DW / 4;

    wr_state_t        state, nxt;
    logic [DW-1:0]    lo_d;
    logic [NIB-1:0]   lo_en;
    logic [AW-1:0]    a_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= W_IDLE;
        else        state <= nxt;
    end

    // transitions
    always_comb begin
        nxt = state;
        unique case (state)
            W_IDLE:   nxt = start ? W_HI : W_IDLE;
            W_HI:     nxt = W_COMMIT;
            W_COMMIT: nxt = start ? W_HI : W_IDLE;
            default:  nxt = W_IDLE;
        endcase
    end

    // outputs
    always_comb commit = (state == W_COMMIT);

    // beat staging and pending word
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lo_d   <= '0;
            lo_en  <= '0;
            a_q    <= '0;
            c_addr <= '0;
            c_word <= '0;
            c_nen  <= '0;
        end else begin
            if (state != W_HI && start) begin
                lo_d  <= din;
                lo_en <= ~mask_n;
                a_q   <= addr;
            end
            if (state == W_HI) begin
                c_addr <= a_q;
                c_word <= {din, lo_d};
                c_nen  <= {~mask_n, lo_en};
            end
        end
    end

endmodule

// File: rtl/sio_array.sv
module sio_array #(
    parameter int DW = 8,
    parameter int AW = 4
) (
    input  logic              clk,
    input  logic              we,
    input  logic [AW-1:0]     waddr,
    input  logic [2*DW-1:0]   wdata,
    input  logic [DW/2-1:0]   nen,
    input  logic [AW-1:0]     raddr,
    output logic [2*DW-1:0]   rdata
);
    localparam int WW    = 2 * DW;
    localparam int WN    = WW / 4;
    localparam int DEPTH = 1 << AW;

    logic [WW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            for (int n = 0; n < WN; n++) begin
                if (nen[n]) mem[waddr][n*4 +: 4] <= wdata[n*4 +: 4];
            end
        end
    end

    assign rdata = mem[raddr];

endmodule

// File: rtl/sio_rd_mux.sv
module sio_rd_mux
    import sio_pkg::*;
#(
    parameter int DW = 8,
    parameter int AW = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [AW-1:0]     addr,
    input  logic [2*DW-1:0]   arr_q,
    input  logic              byp_en,
    input  logic [AW-1:0]     byp_addr,
    input  logic [2*DW-1:0]   byp_word,
    input  logic [DW/2-1:0]   byp_nen,
    output logic              beat_v,
    output logic [DW-1:0]     beat_d
);
    localparam int WW = 2 * DW;
    localparam int WN = WW / 4;

    rd_state_t      state, nxt;
    logic [WW-1:0]  merged;
    logic [DW-1:0]  hi_q;
    logic           hit;

    assign hit = byp_en && (byp_addr == addr);

    // coherence merge, one nibble at a time
    for (genvar n = 0; n < WN; n++) begin : g_nib
        assign merged[n*4 +: 4] = (hit && byp_nen[n]) ? byp_word[n*4 +: 4]
                                                       : arr_q[n*4 +: 4];
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= R_IDLE;
        else        state <= nxt;
    end

    // transitions
    always_comb begin
        nxt = state;
        unique case (state)
            R_IDLE:  nxt = start ? R_HI : R_IDLE;
            R_HI:    nxt = R_IDLE;
            default: nxt = R_IDLE;
        endcase
    end

    // beat outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_q   <= '0;
            beat_v <= 1'b0;
            beat_d <= '0;
        end else if (state == R_IDLE && start) begin
            hi_q   <= merged[WW-1:DW];
            beat_d <= merged[DW-1:0];
            beat_v <= 1'b1;
        end else if (state == R_HI) begin
            beat_d <= hi_q;
            beat_v <= 1'b1;
        end else begin
            beat_d <= '0;
            beat_v <= 1'b0;
        end
    end

endmodule

// File: rtl/sio_out_stage.sv
module sio_out_stage #(
    parameter int DW   = 8,
    parameter int PIPE = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_v,
    input  logic [DW-1:0]   in_d,
    input  logic            fire,
    output logic [DW-1:0]   dout,
    output logic            dvalid,
    output logic            echo
);
    logic           tail_v;
    logic [DW-1:0]  tail_d;

    if (PIPE == 0) begin : g_direct
        assign tail_v = in_v;
        assign tail_d = in_d;
    end else begin : g_pipe
        logic [PIPE-1:0] sv;
        logic [DW-1:0]   sd [PIPE];

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                sv <= '0;
                for (int i = 0; i < PIPE; i++) sd[i] <= '0;
            end else begin
                sv[0] <= in_v;
                sd[0] <= in_d;
                for (int i = 1; i < PIPE; i++) begin
                    sv[i] <= sv[i-1];
                    sd[i] <= sd[i-1];
                end
            end
        end

        assign tail_v = sv[PIPE-1];
        assign tail_d = sd[PIPE-1];
    end

    // output register, clocked by the selected output strobe
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dout   <= '0;
            dvalid <= 1'b0;
            echo   <= 1'b0;
        end else if (fire) begin
            dvalid <= tail_v;
            dout   <= tail_v ? tail_d : '0;
            echo   <= ~echo;
        end
    end

endmodule

// File: rtl/sio_b2_sram.sv
module sio_b2_sram #(
    parameter int DW     = 8,
    parameter int AW     = 4,
    parameter int RD_LAT = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_n,
    input  logic              rd_nwr,
    input  logic [AW-1:0]     addr,
    input  logic [DW-1:0]     din,
    input  logic [DW/4-1:0]   wmask_n,
    input  logic              oclk_tie,
    input  logic              oclk_pulse,
    output logic [DW-1:0]     dout,
    output logic              dvalid,
    output logic              echo,
    output logic              kphase
);
    localparam int WW   = 2 * DW;
    localparam int PIPE = RD_LAT - 2;

    logic              ph;
    logic              acc, wr_go, rd_go;
    logic              wr_commit;
    logic [AW-1:0]     c_addr;
    logic [WW-1:0]     c_word;
    logic [DW/2-1:0]   c_nen;
    logic [WW-1:0]     arr_q;
    logic              beat_v;
    logic [DW-1:0]     beat_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ph <= 1'b0;
        else        ph <= ~ph;
    end

    assign kphase = ph;
    assign acc    = !ld_n && !ph;
    assign wr_go  = acc && !rd_nwr;
    assign rd_go  = acc && rd_nwr;

    sio_wr_demux #(.DW(DW), .AW(AW)) u_wr (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (wr_go),
        .addr   (addr),
        .din    (din),
        .mask_n (wmask_n),
        .commit (wr_commit),
        .c_addr (c_addr),
        .c_word (c_word),
        .c_nen  (c_nen)
    );

    sio_array #(.DW(DW), .AW(AW)) u_arr (
        .clk   (clk),
        .we    (wr_commit),
        .waddr (c_addr),
        .wdata (c_word),
        .nen   (c_nen),
        .raddr (addr),
        .rdata (arr_q)
    );

    sio_rd_mux #(.DW(DW), .AW(AW)) u_rd (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (rd_go),
        .addr     (addr),
        .arr_q    (arr_q),
        .byp_en   (wr_commit),
        .byp_addr (c_addr),
        .byp_word (c_word),
        .byp_nen  (c_nen),
        .beat_v   (beat_v),
        .beat_d   (beat_d)
    );

    sio_out_stage #(.DW(DW), .PIPE(PIPE)) u_out (
        .clk    (clk),
        .rst_n  (rst_n),
        .in_v   (beat_v),
        .in_d   (beat_d),
        .fire   (oclk_tie || oclk_pulse),
        .dout   (dout),
        .dvalid (dvalid),
        .echo   (echo)
    );

endmodule

// File: rtl/sio_b2_checker.sv
module sio_b2_checker #(
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          kphase,
    input logic          ld_n,
    input logic          rd_nwr,
    input logic          oclk_tie,
    input logic          oclk_pulse,
    input logic [DW-1:0] dout,
    input logic          dvalid,
    input logic          echo,
    input logic          arr_we
);

    p_phase_alt_r11: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> kphase != $past(kphase));

    p_idle_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !dvalid |-> dout == '0);

    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!oclk_tie && !oclk_pulse) |=> ($stable(dout) && $stable(dvalid) && $stable(echo)));

    p_echo_flip_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (oclk_tie || oclk_pulse) |=> echo != $past(echo));

    p_commit_age_r12: assert property (@(posedge clk) disable iff (!rst_n)
        arr_we |-> $past(!ld_n && !rd_nwr && !kphase, 2));

endmodule

bind sio_b2_sram sio_b2_checker #(.DW(DW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .kphase     (kphase),
    .ld_n       (ld_n),
    .rd_nwr     (rd_nwr),
    .oclk_tie   (oclk_tie),
    .oclk_pulse (oclk_pulse),
    .dout       (dout),
    .dvalid     (dvalid),
    .echo       (echo),
    .arr_we     (wr_commit)
);

// File: tb/sim_sio_b2_sram.sv
module sim_sio_b2_sram;
    localparam int DW = 8;
    localparam int AW = 4;
    localparam int RD_LAT = 4;

    typedef struct {
        int            when;
        logic [DW-1:0] d;
        int            tag;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ld_n = 1'b1, rd_nwr = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] din = '0;
    logic [1:0] wmask_n = 2'b11;
    logic oclk_tie = 1'b1, oclk_pulse = 1'b0;
    logic [DW-1:0] dout;
    logic dvalid, echo, kphase;

    int checks = 0;
    int errors = 0;
    int ecount = 0;
    bit finished = 0;
    exp_t q[$];
    logic [2*DW-1:0] ref_mem [1 << AW];

    sio_b2_sram #(.DW(DW), .AW(AW), .RD_LAT(RD_LAT)) u0 (
        .clk(clk), .rst_n(rst_n), .ld_n(ld_n), .rd_nwr(rd_nwr), .addr(addr),
        .din(din), .wmask_n(wmask_n), .oclk_tie(oclk_tie), .oclk_pulse(oclk_pulse),
        .dout(dout), .dvalid(dvalid), .echo(echo), .kphase(kphase)
    );

    always #4 clk = ~clk;

    always @(posedge clk) begin
        if (!rst_n) ecount <= 0;
        else        ecount <= ecount + 1;
    end

    function automatic string tname(int t);
        case (t)
            3: return "R3";
            4: return "R4";
            6: return "R6";
            7: return "R7";
            8: return "R8";
            9: return "R9";
            default: return "R2";
        endcase
    endfunction

    task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    // monitor: pops expected beats and compares (R5)
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            if (dvalid) begin
                if (q.size() == 0) begin
                    chk(0, "R5 unexpected beat", {24'd0, dout}, 32'd0);
                end else begin
                    exp_t it;
                    it = q.pop_front();
                    chk(it.when == ecount && dout == it.d,
                        $sformatf("R5 %s beat at %0d", tname(it.tag), it.when),
                        {ecount[23:0], dout}, {it.when[23:0], it.d});
                end
            end else if (q.size() > 0 && q[0].when <= ecount) begin
                exp_t it;
                it = q.pop_front();
                chk(0, $sformatf("R5 %s missing beat", tname(it.tag)),
                    {24'd0, dout}, {24'd0, it.d});
            end
        end
    end

    task automatic wait_ph0();
        @(negedge clk);
        while (kphase) @(negedge clk);
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] b0, input logic [1:0] m0,
                      input logic [DW-1:0] b1, input logic [1:0] m1);
        wait_ph0();
        ld_n = 1'b0; rd_nwr = 1'b0; addr = a; din = b0; wmask_n = m0;
        @(negedge clk);
        ld_n = 1'b1; din = b1; wmask_n = m1;
        for (int n = 0; n < 2; n++) begin
            if (!m0[n]) ref_mem[a][n*4 +: 4] = b0[n*4 +: 4];
            if (!m1[n]) ref_mem[a][8 + n*4 +: 4] = b1[n*4 +: 4];
        end
    endtask

    task automatic rd(input logic [AW-1:0] a, input int tag);
        exp_t e0, e1;
        wait_ph0();
        ld_n = 1'b0; rd_nwr = 1'b1; addr = a;
        e0.when = ecount + RD_LAT; e0.d = ref_mem[a][7:0];  e0.tag = tag;
        e1.when = ecount + RD_LAT + 1; e1.d = ref_mem[a][15:8]; e1.tag = tag;
        q.push_back(e0);
        q.push_back(e1);
        @(negedge clk);
        ld_n = 1'b1;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        #(8 * 20000);
        chk(0, "watchdog expired", 32'd0, 32'd1);
        summary();
    end

    initial begin
        logic e0, e1, p0;
        // R1 reset state
        idle(3);
        chk(dout == 0, "R1 dout in reset", {24'd0, dout}, 0);
        chk(dvalid == 0, "R1 dvalid in reset", {31'd0, dvalid}, 0);
        chk(echo == 0, "R1 echo in reset", {31'd0, echo}, 0);
        chk(kphase == 0, "R1 kphase in reset", {31'd0, kphase}, 0);
        rst_n = 1'b1;
        idle(2);
        // R11 phase alternation
        p0 = kphase;
        @(negedge clk);
        chk(kphase != p0, "R11 kphase alternates", {31'd0, kphase}, {31'd0, ~p0});

        // R3 fill every word, then R6 back-to-back reads
        for (int a = 0; a < 16; a++)
            wr(a[AW-1:0], 8'h10 + 8'(a), 2'b00, 8'hA0 + 8'(a * 3), 2'b00);
        idle(4);
        for (int a = 0; a < 16; a++) rd(a[AW-1:0], (a < 2) ? 3 : 6);
        idle(RD_LAT + 4);

        // R4 nibble masks per beat
        wr(4'd3, 8'hCD, 2'b01, 8'h5E, 2'b10);
        idle(4);
        rd(4'd3, 4);
        idle(RD_LAT + 4);

        // R7 read in the commit slot, then after commit
        wr(4'd5, 8'h9B, 2'b10, 8'h27, 2'b00);
        rd(4'd5, 7);
        rd(4'd6, 7);
        rd(4'd5, 7);
        idle(RD_LAT + 4);

        // R8 write right after a read of the same word
        rd(4'd7, 8);
        wr(4'd7, 8'hF1, 2'b00, 8'h3C, 2'b00);
        rd(4'd7, 8);
        idle(RD_LAT + 4);

        // R2 commands in phase 1 are ignored
        wait_ph0();
        @(negedge clk);
        ld_n = 1'b0; rd_nwr = 1'b0; addr = 4'd9; din = 8'hEE; wmask_n = 2'b00;
        @(negedge clk);
        ld_n = 1'b1;
        @(negedge clk);
        ld_n = 1'b0; rd_nwr = 1'b1; addr = 4'd9;
        @(negedge clk);
        ld_n = 1'b1;
        idle(RD_LAT + 4);
        rd(4'd9, 2);
        idle(RD_LAT + 4);

        // R9 output register frozen without an output strobe
        oclk_tie = 1'b0; oclk_pulse = 1'b0;
        @(negedge clk);
        e0 = echo;
        ld_n = 1'b1;
        wait_ph0();
        ld_n = 1'b0; rd_nwr = 1'b1; addr = 4'd1;
        @(negedge clk);
        ld_n = 1'b1;
        for (int i = 0; i < RD_LAT + 3; i++) begin
            @(negedge clk);
            chk(dvalid == 0 && echo == e0 && dout == 0, "R9 output held",
                {23'd0, echo, dout}, {23'd0, e0, 8'd0});
        end
        idle(3);
        // R9 strobe-driven updates deliver a read
        oclk_pulse = 1'b1;
        idle(2);
        rd(4'd12, 9);
        idle(RD_LAT + 4);
        oclk_pulse = 1'b0; oclk_tie = 1'b1;
        idle(2);
        // R10 echo inverts at every update
        e0 = echo;
        @(negedge clk);
        e1 = echo;
        chk(e1 != e0, "R10 echo inverts", {31'd0, e1}, {31'd0, ~e0});
        @(negedge clk);
        chk(echo != e1, "R10 echo inverts again", {31'd0, echo}, {31'd0, ~e1});

        idle(RD_LAT + 4);
        chk(q.size() == 0, "R5 all beats seen", q.size(), 0);
        summary();
    end
endmodule